// File: doc/BRIEF.md
# Exception and Privilege Controller

This block is the system-control coprocessor of a 32-bit load/store pipeline. It holds four control registers: processor status, exception cause, exception return address and faulting address. Each cycle the pipeline presents its fault and event flags, the PC of the instruction at hand and the PC that would follow it. Six external interrupt lines also come in. The block picks at most one request and reports its code. In the same cycle it tells the fetch stage to restart at the fixed vector. On the next clock edge it captures the return address, the code and, for address faults, the bad address, and it enters kernel mode.

Software reaches the registers through move-from and move-to requests that select a register number. These moves are legal only in kernel mode. In user mode such a move does not execute: it becomes a reserved-instruction fault. A return request sends the fetch stage to the saved return address and drops the processor to user mode.

Top module: `sysctl_cop`

## Requirements
- R1: After reset the processor is in kernel mode, the interrupt enable and all six mask bits are 0, and no exception is signalled. A Status read returns 0x00000002.
- R2: When any request is accepted, `exc_taken` and `redirect` are high in that same cycle with `redirect_pc` = 0x80000180, and `kernel_mode` is 1 from the next cycle.
- R3: The return address register gets `cur_pc` for fetch address errors, fetch and data bus errors and reserved-instruction faults. For syscall, break, overflow, trap, floating point errors and interrupts it gets `next_pc`.
- R4: On a fetch address error the bad-address register gets `cur_pc`. On a data address error it gets `mem_addr`. Every other event leaves it unchanged.
- R5: The code is reported on `exc_code` and stored in Cause bits [6:2]. The codes are: interrupt 0, fetch address error 4, load address error 4, store address error 5, fetch bus error 6, data bus error 7, syscall 8, break 9, reserved 10, overflow 12, trap 13, floating point 15.
- R6: When several requests arrive together, one wins. Fetch address error beats fetch bus error. Fetch faults beat reserved, which beats syscall, which beats break. These beat overflow, then trap, then floating point. Those beat data address error, then data bus error, and interrupts come last.
- R7: Status bit 0 is the global interrupt enable and Status bits [13:8] mask interrupt lines 0..5. An interrupt is taken only when the enable is 1 and some line is high with its mask bit 1.
- R8: Register numbers are 8 bad address, 12 Status, 13 Cause and 14 return address. In kernel mode a read returns the selected register and returns 0 for any other number. Cause bits [13:8] show the live interrupt lines. Writes to Status and the return address take effect at the next edge, and writes to Cause and the bad address are ignored.
- R9: A move-from or move-to in user mode raises code 10 with the return address set to `cur_pc`. It writes nothing, and a read returns 0.
- R10: A return request drives `redirect_pc` to the saved return address in the same cycle, and `kernel_mode` is 0 from the next cycle. If an exception is accepted in the same cycle, the exception wins and the mode stays kernel.
- R11: Status bit 1 is the mode bit (1 = kernel). A kernel-mode Status write that clears it enters user mode at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | 32 | PC of the instruction raising the request |
| next_pc | input | 32 | PC that would execute next |
| fetch_adr_err | input | 1 | Fetch address error |
| fetch_bus_err | input | 1 | Fetch bus error |
| dec_resv | input | 1 | Reserved or undefined opcode |
| dec_sys | input | 1 | Syscall executed |
| dec_brk | input | 1 | Break executed |
| exe_ovf | input | 1 | Integer overflow |
| exe_trap | input | 1 | Trap condition true |
| exe_fpe | input | 1 | Floating point error |
| mem_adr_err | input | 1 | Data address error |
| mem_store | input | 1 | Data access is a store (selects code 5) |
| mem_bus_err | input | 1 | Data bus error |
| mem_addr | input | 32 | Offending data address |
| irq | input | 6 | External interrupt lines |
| cop_rd | input | 1 | Move-from-coprocessor request |
| cop_wr | input | 1 | Move-to-coprocessor request |
| cop_sel | input | 5 | Coprocessor register number |
| cop_wdata | input | 32 | Data for a move-to |
| eret_req | input | 1 | Return-from-exception request |
| cop_rdata | output | 32 | Data for a move-from |
| exc_taken | output | 1 | A request is accepted this cycle |
| exc_code | output | 5 | Code of the accepted request (0 when none) |
| redirect | output | 1 | Fetch must restart at `redirect_pc` |
| redirect_pc | output | 32 | Vector or saved return address |
| kernel_mode | output | 1 | Current mode (1 = kernel) |

## Verification
The bench goes after the split in return-address capture. A design that saved the wrong PC for one class would make a handler re-run a syscall or skip a faulting load. It stacks requests from different stages in one cycle, so a reversed priority chain shows up as the wrong code. It checks that the bad-address register survives a bus error, which catches a design that loads it on every data fault. It also checks that a privileged move in user mode writes nothing and reads zero, which catches a design that leaks kernel state. Finally it puts a return and a syscall in the same cycle, which exposes a design that lets the return drop to user mode.

// File: rtl/sysctl_cop_pkg.sv
package sysctl_cop_pkg;

    localparam int XLEN     = 32;
    localparam int NIRQ     = 6;
    localparam int CODE_W   = 5;
    localparam int SEL_W    = 5;

    // Status layout
    localparam int IE_BIT   = 0;
    localparam int KM_BIT   = 1;
    localparam int MASK_LSB = 8;
    // Cause layout
    localparam int CODE_LSB = 2;
    localparam int PEND_LSB = 8;

    localparam logic [SEL_W-1:0] REG_BADV   = 5'd8;
    localparam logic [SEL_W-1:0] REG_STATUS = 5'd12;
    localparam logic [SEL_W-1:0] REG_CAUSE  = 5'd13;
    localparam logic [SEL_W-1:0] REG_EPC    = 5'd14;

    // Request sources, index 0 has the highest priority
    localparam int S_IFA  = 0;
    localparam int S_IFB  = 1;
    localparam int S_RSV  = 2;
    localparam int S_SYS  = 3;
    localparam int S_BRK  = 4;
    localparam int S_OVF  = 5;
    localparam int S_TRP  = 6;
    localparam int S_FPE  = 7;
    localparam int S_LDA  = 8;
    localparam int S_STA  = 9;
    localparam int S_DBUS = 10;
    localparam int S_IRQ  = 11;
    localparam int NSRC   = 12;

    function automatic logic [CODE_W-1:0] src_code(input int idx);
        case (idx)
            S_IFA:   return 5'd4;
            S_IFB:   return 5'd6;
            S_RSV:   return 5'd10;
            S_SYS:   return 5'd8;
            S_BRK:   return 5'd9;
            S_OVF:   return 5'd12;
            S_TRP:   return 5'd13;
            S_FPE:   return 5'd15;
            S_LDA:   return 5'd4;
            S_STA:   return 5'd5;
            S_DBUS:  return 5'd7;
            default: return 5'd0;
        endcase
    endfunction

    // 1: return address is the faulting PC, 0: the next PC
    function automatic logic src_faulting(input int idx);
        case (idx)
            S_IFA, S_IFB, S_RSV, S_LDA, S_STA, S_DBUS: return 1'b1;
            default:                                   return 1'b0;
        endcase
    endfunction

    typedef struct packed {
        logic              ie;
        logic              kern;
        logic [NIRQ-1:0]   mask;
        logic [CODE_W-1:0] code;
        logic [XLEN-1:0]   epc;
        logic [XLEN-1:0]   badv;
    } cp_state_t;

endpackage

// File: rtl/sysctl_prio.sv
module sysctl_prio
    import sysctl_cop_pkg::*;
(
    input  logic [NSRC-1:0]   req,
    output logic [NSRC-1:0]   grant,
    output logic              any,
    output logic [CODE_W-1:0] code,
    output logic              faulting
);

    always_comb begin
        grant    = '0;
        code     = '0;
        faulting = 1'b0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                code     = src_code(i);
                faulting = src_faulting(i);
            end
        end
        any = |req;
    end

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
    import sysctl_cop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_valid,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              exc_fault,
    input  logic [XLEN-1:0]   fault_pc,
    input  logic [XLEN-1:0]   follow_pc,
    input  logic              badv_ld,
    input  logic [XLEN-1:0]   badv_val,
    input  logic              ret,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [XLEN-1:0]   wr_data,
    output cp_state_t         st_q
);

    cp_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (exc_valid) begin
            st_d.kern = 1'b1;
            st_d.code = exc_code;
            st_d.epc  = exc_fault ? fault_pc : follow_pc;
            if (badv_ld) st_d.badv = badv_val;
        end else if (ret) begin
            st_d.kern = 1'b0;
        end else if (wr_en) begin
            case (wr_sel)
                REG_STATUS: begin
                    st_d.ie   = wr_data[IE_BIT];
                    st_d.kern = wr_data[KM_BIT];
                    st_d.mask = wr_data[MASK_LSB +: NIRQ];
                end
                REG_EPC: st_d.epc = wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ie: 1'b0, kern: 1'b1, mask: '0, code: '0, epc: '0, badv: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assert_epc_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_fault) |=> (st_q.epc == $past(fault_pc)));

    assert_epc_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !exc_fault) |=> (st_q.epc == $past(follow_pc)));

    assert_badv_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!badv_ld) |=> $stable(st_q.badv));

endmodule

// File: rtl/sysctl_cop.sv
module sysctl_cop
    import sysctl_cop_pkg::*;
#(
    parameter logic [XLEN-1:0] VEC_ADDR = 32'h8000_0180
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   next_pc,
    input  logic              fetch_adr_err,
    input  logic              fetch_bus_err,
    input  logic              dec_resv,
    input  logic              dec_sys,
    input  logic              dec_brk,
    input  logic              exe_ovf,
    input  logic              exe_trap,
    input  logic              exe_fpe,
    input  logic              mem_adr_err,
    input  logic              mem_store,
    input  logic              mem_bus_err,
    input  logic [XLEN-1:0]   mem_addr,
    input  logic [NIRQ-1:0]   irq,
    input  logic              cop_rd,
    input  logic              cop_wr,
    input  logic [SEL_W-1:0]  cop_sel,
    input  logic [XLEN-1:0]   cop_wdata,
    input  logic              eret_req,
    output logic [XLEN-1:0]   cop_rdata,
    output logic              exc_taken,
    output logic [CODE_W-1:0] exc_code,
    output logic              redirect,
    output logic [XLEN-1:0]   redirect_pc,
    output logic              kernel_mode
);

    cp_state_t         st_q;
    logic [NSRC-1:0]   req;
    logic [NSRC-1:0]   grant;
    logic              any;
    logic [CODE_W-1:0] code;
    logic              faulting;
    logic              priv_viol;
    logic              irq_hit;
    logic              badv_ld;
    logic [XLEN-1:0]   badv_val;
    logic [XLEN-1:0]   status_w;
    logic [XLEN-1:0]   cause_w;
    logic [XLEN-1:0]   rd_mux;

    assign priv_viol = !st_q.kern && (cop_rd || cop_wr);
    assign irq_hit   = st_q.ie && |(irq & st_q.mask);

    always_comb begin
        req         = '0;
        req[S_IFA]  = fetch_adr_err;
        req[S_IFB]  = fetch_bus_err;
        req[S_RSV]  = dec_resv || priv_viol;
        req[S_SYS]  = dec_sys;
        req[S_BRK]  = dec_brk;
        req[S_OVF]  = exe_ovf;
        req[S_TRP]  = exe_trap;
        req[S_FPE]  = exe_fpe;
        req[S_LDA]  = mem_adr_err && !mem_store;
        req[S_STA]  = mem_adr_err && mem_store;
        req[S_DBUS] = mem_bus_err;
        req[S_IRQ]  = irq_hit;
    end

    sysctl_prio u_prio (
        .req      (req),
        .grant    (grant),
        .any      (any),
        .code     (code),
        .faulting (faulting)
    );

    assign badv_ld  = grant[S_IFA] || grant[S_LDA] || grant[S_STA];
    assign badv_val = grant[S_IFA] ? cur_pc : mem_addr;

    sysctl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .exc_valid (any),
        .exc_code  (code),
        .exc_fault (faulting),
        .fault_pc  (cur_pc),
        .follow_pc (next_pc),
        .badv_ld   (badv_ld),
        .badv_val  (badv_val),
        .ret       (eret_req),
        .wr_en     (cop_wr && st_q.kern),
        .wr_sel    (cop_sel),
        .wr_data   (cop_wdata),
        .st_q      (st_q)
    );

    always_comb begin
        status_w                       = '0;
        status_w[IE_BIT]               = st_q.ie;
        status_w[KM_BIT]               = st_q.kern;
        status_w[MASK_LSB +: NIRQ]     = st_q.mask;
        cause_w                        = '0;
        cause_w[CODE_LSB +: CODE_W]    = st_q.code;
        cause_w[PEND_LSB +: NIRQ]      = irq;
        case (cop_sel)
            REG_BADV:   rd_mux = st_q.badv;
            REG_STATUS: rd_mux = status_w;
            REG_CAUSE:  rd_mux = cause_w;
            REG_EPC:    rd_mux = st_q.epc;
            default:    rd_mux = '0;
        endcase
    end

    assign cop_rdata   = (cop_rd && st_q.kern) ? rd_mux : '0;
    assign exc_taken   = any;
    assign exc_code    = code;
    assign redirect    = any || eret_req;
    assign redirect_pc = any ? VEC_ADDR : st_q.epc;
    assign kernel_mode = st_q.kern;

    assert_onehot_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> (redirect && redirect_pc == VEC_ADDR));

    assert_kernel_after_exc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |=> kernel_mode);

    assert_user_after_ret_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eret_req && !exc_taken) |=> !kernel_mode);

    assert_priv_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!kernel_mode && (cop_rd || cop_wr)) |-> (exc_taken && cop_rdata == '0));

    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_taken && exc_code == '0) |-> (st_q.ie && |(irq & st_q.mask)));

endmodule

// File: tb/sysctl_cop_tb.sv
module sysctl_cop_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] VEC = 32'h8000_0180;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc = '0, next_pc = '0, mem_addr = '0, cop_wdata = '0;
    logic        fetch_adr_err = 0, fetch_bus_err = 0, dec_resv = 0, dec_sys = 0, dec_brk = 0;
    logic        exe_ovf = 0, exe_trap = 0, exe_fpe = 0, mem_adr_err = 0, mem_store = 0, mem_bus_err = 0;
    logic [5:0]  irq = '0;
    logic        cop_rd = 0, cop_wr = 0, eret_req = 0;
    logic [4:0]  cop_sel = '0;
    logic [31:0] cop_rdata, redirect_pc;
    logic        exc_taken, redirect, kernel_mode;
    logic [4:0]  exc_code;

    sysctl_cop u_dut (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .next_pc(next_pc),
        .fetch_adr_err(fetch_adr_err), .fetch_bus_err(fetch_bus_err),
        .dec_resv(dec_resv), .dec_sys(dec_sys), .dec_brk(dec_brk),
        .exe_ovf(exe_ovf), .exe_trap(exe_trap), .exe_fpe(exe_fpe),
        .mem_adr_err(mem_adr_err), .mem_store(mem_store), .mem_bus_err(mem_bus_err),
        .mem_addr(mem_addr), .irq(irq), .cop_rd(cop_rd), .cop_wr(cop_wr),
        .cop_sel(cop_sel), .cop_wdata(cop_wdata), .eret_req(eret_req),
        .cop_rdata(cop_rdata), .exc_taken(exc_taken), .exc_code(exc_code),
        .redirect(redirect), .redirect_pc(redirect_pc), .kernel_mode(kernel_mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        string       tag;
        logic        taken;
        logic [4:0]  code;
        logic        redir;
        logic [31:0] rpc;
        logic        kern;
        logic [31:0] rdata;
    } exp_t;

    exp_t q[$];
    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model of the visible state, built from the requirements
    logic        m_kern = 1, m_ie = 0;
    logic [5:0]  m_mask = '0;
    logic [4:0]  m_code = '0;
    logic [31:0] m_epc = '0, m_badv = '0;

    function automatic logic [31:0] model_read(input logic [4:0] sel);
        case (sel)
            5'd8:  return m_badv;
            5'd12: return {18'b0, m_mask, 6'b0, m_kern, m_ie};
            5'd13: return {18'b0, irq, 1'b0, m_code, 2'b0};
            5'd14: return m_epc;
            default: return 32'h0;
        endcase
    endfunction

    task automatic idle();
        fetch_adr_err = 0; fetch_bus_err = 0; dec_resv = 0; dec_sys = 0; dec_brk = 0;
        exe_ovf = 0; exe_trap = 0; exe_fpe = 0; mem_adr_err = 0; mem_store = 0; mem_bus_err = 0;
        cop_rd = 0; cop_wr = 0; eret_req = 0; irq = '0;
    endtask

    // inputs already set at a falling edge; predict, push, advance model
    task automatic cycle(input string tag);
        exp_t e;
        logic priv, ih, tk, flt, bl;
        logic [4:0] c;
        logic [31:0] bv;
        priv = !m_kern && (cop_rd || cop_wr);
        ih   = m_ie && |(irq & m_mask);
        tk = 1; flt = 0; bl = 0; bv = '0; c = '0;
        if (fetch_adr_err)        begin c = 4;  flt = 1; bl = 1; bv = cur_pc; end
        else if (fetch_bus_err)   begin c = 6;  flt = 1; end
        else if (dec_resv || priv) begin c = 10; flt = 1; end
        else if (dec_sys)         c = 8;
        else if (dec_brk)         c = 9;
        else if (exe_ovf)         c = 12;
        else if (exe_trap)        c = 13;
        else if (exe_fpe)         c = 15;
        else if (mem_adr_err)     begin c = mem_store ? 5'd5 : 5'd4; flt = 1; bl = 1; bv = mem_addr; end
        else if (mem_bus_err)     begin c = 7;  flt = 1; end
        else if (ih)              c = 0;
        else                      tk = 0;
        e.tag   = tag;
        e.taken = tk;
        e.code  = tk ? c : 5'd0;
        e.redir = tk || eret_req;
        e.rpc   = tk ? VEC : m_epc;
        e.kern  = m_kern;
        e.rdata = (cop_rd && m_kern) ? model_read(cop_sel) : 32'h0;
        q.push_back(e);
        if (tk) begin
            m_kern = 1; m_code = c;
            m_epc = flt ? cur_pc : next_pc;
            if (bl) m_badv = bv;
        end else if (eret_req) begin
            m_kern = 0;
        end else if (cop_wr && m_kern) begin
            if (cop_sel == 5'd12) begin
                m_ie = cop_wdata[0]; m_kern = cop_wdata[1]; m_mask = cop_wdata[13:8];
            end else if (cop_sel == 5'd14) begin
                m_epc = cop_wdata;
            end
        end
        @(negedge clk);
        idle();
    endtask

    task automatic rd(input logic [4:0] sel, input string tag);
        cop_rd = 1; cop_sel = sel; cycle(tag);
    endtask

    task automatic wr(input logic [4:0] sel, input logic [31:0] d, input string tag);
        cop_wr = 1; cop_sel = sel; cop_wdata = d; cycle(tag);
    endtask

    task automatic pcs(input logic [31:0] c);
        cur_pc = c; next_pc = c + 4;
    endtask

    // monitor: compare every pushed item a quarter period after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (exc_taken !== e.taken || exc_code !== e.code || redirect !== e.redir ||
                    (e.redir && redirect_pc !== e.rpc) || kernel_mode !== e.kern ||
                    cop_rdata !== e.rdata) begin
                    bad++;
                    $display("FAIL %s: got taken=%b code=%0d redir=%b pc=%h kern=%b rdata=%h exp taken=%b code=%0d redir=%b pc=%h kern=%b rdata=%h",
                             e.tag, exc_taken, exc_code, redirect, redirect_pc, kernel_mode, cop_rdata,
                             e.taken, e.code, e.redir, e.rpc, e.kern, e.rdata);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(5'd12, "R1 status after reset");
        cycle("R1 idle no exception");
        // R8 map and write effects
        rd(5'd3,  "R8 unmapped read zero");
        wr(5'd14, 32'h1234_5678, "R8 write epc");
        rd(5'd14, "R8 read epc");
        wr(5'd13, 32'hFFFF_FFFF, "R8 cause write ignored");
        rd(5'd13, "R8 cause unchanged");
        wr(5'd8,  32'hAAAA_5555, "R8 badv write ignored");
        rd(5'd8,  "R8 badv unchanged");
        // R5/R3 next-pc classes
        pcs(32'h100); dec_sys  = 1; cycle("R5 syscall code 8");
        rd(5'd14, "R3 syscall epc next"); rd(5'd13, "R5 cause syscall");
        pcs(32'h110); dec_brk  = 1; cycle("R5 break code 9");   rd(5'd13, "R5 cause break");
        pcs(32'h120); exe_ovf  = 1; cycle("R5 overflow code 12"); rd(5'd14, "R3 overflow epc next");
        pcs(32'h130); exe_trap = 1; cycle("R5 trap code 13");    rd(5'd13, "R5 cause trap");
        pcs(32'h140); exe_fpe  = 1; cycle("R5 fpe code 15");     rd(5'd14, "R3 fpe epc next");
        // faulting classes
        pcs(32'h200); dec_resv = 1; cycle("R5 reserved code 10"); rd(5'd14, "R3 reserved epc fault");
        pcs(32'h301); fetch_adr_err = 1; cycle("R5 fetch addr code 4");
        rd(5'd8, "R4 badv fetch pc"); rd(5'd14, "R3 fetch addr epc fault");
        pcs(32'h310); fetch_bus_err = 1; cycle("R5 fetch bus code 6"); rd(5'd14, "R3 fetch bus epc fault");
        pcs(32'h320); mem_adr_err = 1; mem_addr = 32'hDEAD_BEEF; cycle("R5 load addr code 4");
        rd(5'd8, "R4 badv load addr");
        pcs(32'h330); mem_adr_err = 1; mem_store = 1; mem_addr = 32'hCAFE_0002; cycle("R5 store addr code 5");
        rd(5'd8, "R4 badv store addr");
        pcs(32'h340); mem_bus_err = 1; mem_addr = 32'h1111_1111; cycle("R5 data bus code 7");
        rd(5'd8, "R4 badv kept on bus error"); rd(5'd14, "R3 data bus epc fault");
        // R6 priority
        pcs(32'h400); dec_sys = 1; exe_ovf = 1; mem_bus_err = 1; cycle("R6 syscall over ovf and bus");
        pcs(32'h410); fetch_bus_err = 1; dec_resv = 1; cycle("R6 fetch bus over reserved");
        pcs(32'h420); exe_ovf = 1; exe_trap = 1; exe_fpe = 1; cycle("R6 ovf over trap and fpe");
        pcs(32'h430); fetch_adr_err = 1; fetch_bus_err = 1; cycle("R6 fetch addr over fetch bus");
        pcs(32'h440); dec_resv = 1; dec_brk = 1; cycle("R6 reserved over break");
        pcs(32'h450); exe_fpe = 1; mem_adr_err = 1; cycle("R6 fpe over data addr");
        // R7 interrupt gating
        wr(5'd12, 32'h0000_0003, "R7 enable only");
        pcs(32'h500); irq = 6'b000100; cycle("R7 masked line ignored");
        wr(5'd12, 32'h0000_0403, "R7 unmask line 2");
        pcs(32'h510); irq = 6'b000100; cycle("R7 interrupt code 0");
        rd(5'd14, "R3 interrupt epc next");
        pcs(32'h520); irq = 6'b110000; cycle("R7 other lines ignored");
        pcs(32'h530); irq = 6'b000100; mem_adr_err = 1; mem_addr = 32'h77; cycle("R6 data addr over irq");
        wr(5'd12, 32'h0000_0402, "R7 global disable");
        pcs(32'h540); irq = 6'b000100; cycle("R7 disabled not taken");
        irq = 6'b100100; rd(5'd13, "R8 cause live lines");
        // R10 return
        wr(5'd14, 32'h0000_4000, "R10 set epc");
        eret_req = 1; cycle("R10 return redirect");
        cycle("R10 user mode after return");
        // R9 privilege
        pcs(32'h600); cop_rd = 1; cop_sel = 5'd12; cycle("R9 user read faults");
        rd(5'd14, "R9 epc fault pc");
        wr(5'd12, 32'h0000_0000, "R11 drop to user via status");
        pcs(32'h610); cop_wr = 1; cop_sel = 5'd14; cop_wdata = 32'h9999_9999; cycle("R9 user write faults");
        rd(5'd14, "R9 user write ignored");
        rd(5'd12, "R11 kernel after fault");
        // R10 conflict
        pcs(32'h700); eret_req = 1; dec_sys = 1; cycle("R10 exception beats return");
        cycle("R10 stays kernel");
        repeat (2) @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule